// File: doc/BRIEF.md
# Centre-aligned PWM timer channel

This block is one timer/counter channel that runs only as a centre-aligned pulse-width modulator. An 8-bit counter climbs from zero to the all-ones value and then falls back to zero. It advances only on cycles where the prescaler's count-enable strobe is high. A comparator checks the counter against an active compare value. On a match while climbing, the waveform moves one way. On a match while falling, it moves the other way. Each pulse is therefore centred on the top or the bottom of the count.

The host writes a new compare value into a buffer. The active value is taken from that buffer only when the counter arrives at the top, so a pulse is never cut short or made lopsided part-way through. A two-bit mode field selects one of three output behaviours: waveform off (pin held low), non-inverting, or inverting. Two sticky flags report when the counter reaches the bottom and when a compare match occurs. The host clears each flag with a one-cycle clear pulse.

Top module: `pcpwm_timer`

## Requirements
- R1: On enabled ticks the count rises by one from 0 to 255. It shows 255 for exactly one enabled tick, then falls by one back to 0, then rises again. Reset leaves it at 0 and rising.
- R2: On a cycle where `cnt_en` is low, the count, waveform and flags hold their values, except for any flag clear requested that cycle.
- R3: Between successive arrivals at 0 there are exactly 510 enabled ticks. `ovf_flag` is set on the tick that brings the count down to 0.
- R4: Mode 2'b10 (non-inverting): `pwm_out` goes low after an enabled tick on which the count equals the active compare value while rising. It goes high after such a tick while falling.
- R5: Mode 2'b11 (inverting): `pwm_out` is the complement of the mode 2'b10 waveform. It goes high on the rising match and low on the falling match.
- R6: Modes 2'b00 and 2'b01 drive `pwm_out` low one cycle after the mode is applied, whatever the counter does.
- R7: A compare write (`cmp_wr`) stores `cmp_wdata` in a buffer. The active compare value is loaded from the buffer only on the tick that takes the count to 255, so a write made mid-period does not affect that period's matches.
- R8: `cmp_flag` is set after any enabled tick on which the count equals the active compare value. `flag_clr[1]` clears it and `flag_clr[0]` clears `ovf_flag`. If a set and a clear fall in the same cycle, the set wins.
- R9: With an active compare value of 0x00, mode 2'b10 keeps `pwm_out` low for the whole period. With 0xFF, it keeps `pwm_out` high.
- R10: During and right after reset, `count`, `pwm_out`, `ovf_flag` and `cmp_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-enable strobe from the prescaler |
| cmp_wr | input | 1 | Compare buffer write strobe |
| cmp_wdata | input | 8 | Compare value to buffer |
| out_mode | input | 2 | Output mode: 00/01 off, 10 non-inverting, 11 inverting |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 compare |
| count | output | 8 | Current counter value |
| pwm_out | output | 1 | Waveform output |
| ovf_flag | output | 1 | Sticky bottom-reached flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
The bench targets the turnaround at 255. A counter that wraps instead of reversing, or that holds the top for two ticks, breaks the 510-tick period. It also targets the extreme compare values 0x00 and 0xFF: a direction bit updated in the wrong cycle would produce a one-tick glitch there instead of a flat output. A compare value written in the middle of a rising slope checks that buffering is honoured; a design that loaded it at once would clear the output early. Random enable gaps, flag clears that land on the same cycle as a set, and mode changes check that stalled cycles hold state and that a set beats a clear.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;
  typedef enum logic [1:0] {
    OUT_OFF_A  = 2'b00,
    OUT_OFF_B  = 2'b01,
    OUT_NONINV = 2'b10,
    OUT_INV    = 2'b11
  } out_mode_e;

  localparam int FLAG_OVF = 0;
  localparam int FLAG_CMP = 1;
endpackage

// File: rtl/pcpwm_counter.sv
module pcpwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         dir_up,
  output logic         hit_top,
  output logic         hit_bot
);
  localparam logic [W-1:0] TOP     = {W{1'b1}};
  localparam logic [W-1:0] TOP_M1  = TOP - 1'b1;
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] nxt;

  always_comb begin
    nxt     = dir_up ? count + 1'b1 : count - 1'b1;
    hit_top = tick && dir_up && (count == TOP_M1);
    hit_bot = tick && !dir_up && (count == ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      dir_up <= 1'b1;
    end else if (tick) begin
      count <= nxt;
      if (hit_top) dir_up <= 1'b0;
      if (hit_bot) dir_up <= 1'b1;
    end
  end
endmodule

// File: rtl/pcpwm_cmp_buf.sv
module pcpwm_cmp_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] active
);
  logic [W-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (wr)   shadow <= wdata;
      if (load) active <= shadow;
    end
  end
endmodule

// File: rtl/pcpwm_wave.sv
module pcpwm_wave #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic         dir_up,
  input  logic [W-1:0] active,
  input  logic [1:0]   mode,
  output logic         match,
  output logic         pwm_out
);
  logic wave, wave_n;

  always_comb begin
    match  = tick && (count == active);
    wave_n = match ? !dir_up : wave;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wave    <= 1'b0;
      pwm_out <= 1'b0;
    end else begin
      wave    <= wave_n;
      pwm_out <= mode[1] & (wave_n ^ mode[0]);
    end
  end
endmodule

// File: rtl/pcpwm_flags.sv
module pcpwm_flags #(
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] flags
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [1:0]       out_mode,
  input  logic [1:0]       flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             pwm_out,
  output logic             ovf_flag,
  output logic             cmp_flag
);
  import pcpwm_pkg::*;

  logic             dir_up, hit_top, hit_bot, match;
  logic [CNT_W-1:0] cmp_act;
  logic [1:0]       fset, fval;

  pcpwm_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(cnt_en), .count(count),
    .dir_up(dir_up), .hit_top(hit_top), .hit_bot(hit_bot)
  );

  pcpwm_cmp_buf #(.W(CNT_W)) u_buf (
    .clk(clk), .rst(rst), .wr(cmp_wr), .wdata(cmp_wdata),
    .load(hit_top), .active(cmp_act)
  );

  pcpwm_wave #(.W(CNT_W)) u_wave (
    .clk(clk), .rst(rst), .tick(cnt_en), .count(count), .dir_up(dir_up),
    .active(cmp_act), .mode(out_mode), .match(match), .pwm_out(pwm_out)
  );

  always_comb begin
    fset           = '0;
    fset[FLAG_OVF] = hit_bot;
    fset[FLAG_CMP] = match;
  end

  pcpwm_flags #(.NF(2)) u_flags (
    .clk(clk), .rst(rst), .set(fset), .clr(flag_clr), .flags(fval)
  );

  assign ovf_flag = fval[FLAG_OVF];
  assign cmp_flag = fval[FLAG_CMP];
endmodule

// File: rtl/pcpwm_timer_chk.sv
module pcpwm_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic [1:0]       out_mode,
  input logic [CNT_W-1:0] count,
  input logic             dir_up,
  input logic [CNT_W-1:0] cmp_act,
  input logic             pwm_out,
  input logic             ovf_flag,
  input logic             cmp_flag
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> (count == $past(count) + ONE) || (count == $past(count) - ONE));

  p_top_turn_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count == TOP) |=> (count == TOP - ONE));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(count));

  p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !dir_up && count == ONE) |=> ovf_flag);

  p_off_low_r6: assert property (@(posedge clk) disable iff (rst)
    !out_mode[1] |=> !pwm_out);

  p_cmp_set_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count == cmp_act) |=> cmp_flag);
endmodule

bind pcpwm_timer pcpwm_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .out_mode(out_mode),
  .count(count), .dir_up(dir_up), .cmp_act(cmp_act),
  .pwm_out(pwm_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
);

// File: tb/test_pcpwm_timer.sv
module test_pcpwm_timer;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic       cmp_wr = 1'b0;
  logic [7:0] cmp_wdata = '0;
  logic [1:0] out_mode = 2'b10;
  logic [1:0] flag_clr = '0;
  logic [7:0] count;
  logic       pwm_out, ovf_flag, cmp_flag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_cnt, m_buf, m_act;
  logic       m_up, m_wave, m_out, m_ovf, m_cmp;

  always #(CLK_NS/2) clk = ~clk;

  pcpwm_timer i_pcpwm_timer (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cmp_wr(cmp_wr),
    .cmp_wdata(cmp_wdata), .out_mode(out_mode), .flag_clr(flag_clr),
    .count(count), .pwm_out(pwm_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_buf = 0; m_act = 0; m_up = 1;
    m_wave = 0; m_out = 0; m_ovf = 0; m_cmp = 0;
  endtask

  // next-state from requirements R1..R9
  task automatic model_step();
    logic match, bot, top;
    logic [7:0] nc;
    match = cnt_en && (m_cnt == m_act);
    nc = m_up ? m_cnt + 8'd1 : m_cnt - 8'd1;
    top = cnt_en && m_up && (nc == 8'hFF);
    bot = cnt_en && !m_up && (nc == 8'h00);
    if (match) m_wave = !m_up;
    m_out = out_mode[1] & (m_wave ^ out_mode[0]);
    m_ovf = bot | (m_ovf & ~flag_clr[0]);
    m_cmp = match | (m_cmp & ~flag_clr[1]);
    if (top) m_act = m_buf;
    if (cmp_wr) m_buf = cmp_wdata;
    if (cnt_en) m_cnt = nc;
    if (top) m_up = 0;
    if (bot) m_up = 1;
  endtask

  task automatic step(bit en, bit wr, logic [7:0] wd, logic [1:0] md, logic [1:0] clr);
    @(negedge clk);
    cnt_en = en; cmp_wr = wr; cmp_wdata = wd; out_mode = md; flag_clr = clr;
    model_step();
    @(posedge clk);
    #2;
    check("R1 R2 count", count, m_cnt);
    check("R4 R5 R6 pwm_out", pwm_out, m_out);
    check("R3 ovf_flag", ovf_flag, m_ovf);
    check("R8 cmp_flag", cmp_flag, m_cmp);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int last0, cyc, hi;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    check("R10 reset count", count, 0);
    check("R10 reset pwm", pwm_out, 0);
    check("R10 reset ovf", ovf_flag, 0);
    check("R10 reset cmp", cmp_flag, 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #2;
    check("R10 after reset count", count, 0);

    // R3: period with continuous enable, compare 128
    step(1, 1, 8'd128, 2'b10, 2'b00);
    last0 = -1; cyc = 0;
    for (int i = 0; i < 1600; i++) begin
      step(1, 0, 8'd0, 2'b10, 2'b00);
      cyc++;
      if (count == 8'd0) begin
        if (last0 >= 0) check("R3 period ticks", cyc - last0, 510);
        last0 = cyc;
      end
    end

    // R9: compare 0x00 then 0xFF, non-inverting
    step(1, 1, 8'h00, 2'b10, 2'b00);
    for (int i = 0; i < 520; i++) step(1, 0, 8'd0, 2'b10, 2'b00);
    hi = 0;
    for (int i = 0; i < 510; i++) begin
      step(1, 0, 8'd0, 2'b10, 2'b00);
      hi += pwm_out;
    end
    check("R9 zero compare high cycles", hi, 0);
    step(1, 1, 8'hFF, 2'b10, 2'b00);
    for (int i = 0; i < 1020; i++) step(1, 0, 8'd0, 2'b10, 2'b00);
    hi = 0;
    for (int i = 0; i < 510; i++) begin
      step(1, 0, 8'd0, 2'b10, 2'b00);
      hi += pwm_out;
    end
    check("R9 full compare high cycles", hi, 510);

    // R7: load 200, then write 30 mid rising slope
    step(1, 1, 8'd200, 2'b10, 2'b00);
    for (int i = 0; i < 1020; i++) step(1, 0, 8'd0, 2'b10, 2'b00);
    while (!(count == 8'd10 && m_up)) step(1, 0, 8'd0, 2'b10, 2'b00);
    step(1, 1, 8'd30, 2'b10, 2'b00);
    while (count != 8'd40) step(1, 0, 8'd0, 2'b10, 2'b00);
    check("R7 buffered write ignored mid period", pwm_out, 1);
    // R5 and R6 quick directed
    step(0, 0, 8'd0, 2'b11, 2'b00);
    check("R5 inverted level", pwm_out, 0);
    step(0, 0, 8'd0, 2'b01, 2'b00);
    check("R6 off mode low", pwm_out, 0);
    // R8 set beats clear: match and clear together
    while (count != 8'd29) step(1, 0, 8'd0, 2'b10, 2'b11);
    step(1, 0, 8'd0, 2'b10, 2'b11);
    step(1, 0, 8'd0, 2'b10, 2'b10);
    check("R8 flag cleared", cmp_flag, 0);

    // random phase
    for (int i = 0; i < 30000; i++) begin
      bit en, wr;
      logic [1:0] md, clr;
      en = ($urandom % 10) < 7;
      wr = ($urandom % 200) == 0;
      md = (($urandom % 500) == 0) ? 2'($urandom) : out_mode;
      clr = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      step(en, wr, 8'($urandom), md, clr);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule